// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Sweep Engine

This engine picks the receive sampling delay for a high-speed memory-card link. Software or a sequencer pulses a start input. The engine then walks a tune code upward from zero through a limited window of the code space. For each code it raises an update request and waits for the delay logic to report that the update has finished. It then asks the card side for one tuning-block transfer and reads back a pass or fail result.

While it sweeps, the engine keeps two counts: the length of the passing run in progress, and the longest passing run found so far together with that run's last passing code. At the end of the sweep it computes the centre of the longest run and applies that code through one more update handshake. It then pulses done. If no code passed, it pulses done and error together and applies no code.

An update that does not finish within a bounded number of cycles counts as a failed step, and no transfer is requested for that code. The card command logic and the delay line sit outside the block and talk to it only through these handshakes.

Top module: `tune_sweep_engine`

## Requirements
- R1: When idle, a start pulse clears the run bookkeeping and begins the sweep at tune code 0 with the update request raised on the next cycle. A start pulse during a sweep is ignored and does not restart the sweep.
- R2: The sweep applies every code from 0 to SWEEP_STEPS-1 exactly once, in ascending order. It never applies a code at or above SWEEP_STEPS, even though the TUNE_W-bit field can hold larger values.
- R3: For each step, the update request stays high with the tune code stable until update-done is seen. The transfer request rises only after that and stays high until a result strobe (res_valid_i high, with res_pass_i high meaning pass) arrives. Exactly one transfer is requested per completed update.
- R4: If update-done does not arrive within UPD_LIMIT cycles of the update request, the step counts as a fail. No transfer is requested for that code, and the sweep moves to the next code.
- R5: A failing step resets the current run length to zero. The longest run is replaced only when the current run becomes strictly longer, so the earliest of equally long runs is kept. A run that reaches the top code is closed at the end of the sweep and never joined with a run at code 0.
- R6: The final code is the last passing code of the longest run minus half that run's length, rounded down. It is applied through the same update handshake.
- R7: After the final update completes, done_o is high for exactly one cycle with err_o low, and tune_o holds the final code.
- R8: If no step passes, done_o and err_o are high together for one cycle, no final update is requested, and tune_o keeps the last swept code.
- R9: If the final update does not complete within UPD_LIMIT cycles, done_o and err_o are pulsed together for one cycle.
- R10: After reset, tune_o is 0 and upd_req_o, xfer_req_o, done_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| upd_done_i | input | 1 | Delay logic reports that the pending tune update has completed |
| res_valid_i | input | 1 | Strobe marking a valid tuning-block result |
| res_pass_i | input | 1 | Tuning-block result, 1 = pass, sampled with res_valid_i |
| tune_o | output | TUNE_W | Tune code being applied |
| upd_req_o | output | 1 | Update request, held until update-done or timeout |
| xfer_req_o | output | 1 | Tuning-block transfer request, held until the result strobe |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse, only together with done_o |

## Verification
The bench builds the engine with TUNE_W=6 and SWEEP_STEPS=40, so the sweep stops well below the 64 codes the field can hold. With these values a run ending at the top code and a run starting at code 0 can be placed so that joining them across the wrap would change the chosen centre. UPD_LIMIT is reduced to 6 so that stalled updates, both during the sweep and for the final code, time out within a few cycles. The card-side responder is driven from per-code pass and stall masks, which makes the tie, single-point, empty and edge-of-range windows reachable within a short run.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UPD,
    ST_XFER,
    ST_EVAL,
    ST_FIN
  } tsw_state_e;

  // Centre of a passing window given its last passing code and length.
  function automatic int unsigned tsw_centre(input int unsigned last_code,
                                             input int unsigned run_len);
    return last_code - (run_len / 2);
  endfunction

endpackage

// File: rtl/tsw_upd_timer.sv
module tsw_upd_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired_o = run_i && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run_i || expired_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tsw_run_tracker.sv
module tsw_run_tracker #(
  parameter int TUNE_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              pass_i,
  input  logic [TUNE_W-1:0] code_i,
  output logic [CNT_W-1:0]  best_len_o,
  output logic [TUNE_W-1:0] best_last_o
);
  logic [CNT_W-1:0] cur_len;
  logic [CNT_W-1:0] cur_next;
  logic             longer;

  assign cur_next = cur_len + 1'b1;
  assign longer   = cur_next > best_len_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_len     <= '0;
      best_len_o  <= '0;
      best_last_o <= '0;
    end else if (clr_i) begin
      cur_len     <= '0;
      best_len_o  <= '0;
      best_last_o <= '0;
    end else if (step_i) begin
      if (pass_i) begin
        cur_len <= cur_next;
        if (longer) begin
          best_len_o  <= cur_next;
          best_last_o <= code_i;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end
endmodule

// File: rtl/tune_sweep_engine.sv
module tune_sweep_engine
  import tsw_pkg::*;
#(
  parameter int TUNE_W      = 6,
  parameter int SWEEP_STEPS = 40,
  parameter int UPD_LIMIT   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              upd_done_i,
  input  logic              res_valid_i,
  input  logic              res_pass_i,
  output logic [TUNE_W-1:0] tune_o,
  output logic              upd_req_o,
  output logic              xfer_req_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(SWEEP_STEPS + 1);
  localparam logic [TUNE_W-1:0] LAST_CODE = TUNE_W'(SWEEP_STEPS - 1);

  tsw_state_e        st;
  logic [TUNE_W-1:0] code;
  logic [CNT_W-1:0]  best_len;
  logic [TUNE_W-1:0] best_last;
  logic [TUNE_W-1:0] centre;

  // Named internal events
  logic upd_wait;
  logic upd_timeout;
  logic sweep_phase;
  logic sweep_clr;
  logic step_fire;
  logic step_pass;
  logic sweep_last;

  assign upd_wait    = (st == ST_UPD) || (st == ST_FIN);
  assign sweep_phase = (st == ST_UPD) || (st == ST_XFER);
  assign sweep_clr   = (st == ST_IDLE) && start_i;
  assign step_fire   = ((st == ST_UPD) && !upd_done_i && upd_timeout) ||
                       ((st == ST_XFER) && res_valid_i);
  assign step_pass   = (st == ST_XFER) && res_valid_i && res_pass_i;
  assign sweep_last  = (code == LAST_CODE);
  assign centre      = TUNE_W'(tsw_centre(32'(best_last), 32'(best_len)));

  assign upd_req_o  = upd_wait;
  assign xfer_req_o = (st == ST_XFER);

  tsw_upd_timer #(
    .LIMIT(UPD_LIMIT)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (upd_wait),
    .expired_o(upd_timeout)
  );

  tsw_run_tracker #(
    .TUNE_W(TUNE_W),
    .CNT_W (CNT_W)
  ) i_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sweep_clr),
    .step_i     (step_fire),
    .pass_i     (step_pass),
    .code_i     (code),
    .best_len_o (best_len),
    .best_last_o(best_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      code   <= '0;
      tune_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            code   <= '0;
            tune_o <= '0;
            st     <= ST_UPD;
          end
        end
        ST_UPD: begin
          if (upd_done_i) st <= ST_XFER;
        end
        ST_XFER: ;
        ST_EVAL: begin
          if (best_len == '0) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            tune_o <= centre;
            st     <= ST_FIN;
          end
        end
        ST_FIN: begin
          if (upd_done_i) begin
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else if (upd_timeout) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (step_fire) begin
        if (sweep_last) begin
          st <= ST_EVAL;
        end else begin
          code   <= code + 1'b1;
          tune_o <= code + 1'b1;
          st     <= ST_UPD;
        end
      end
    end
  end

  initial begin
    if (SWEEP_STEPS > (1 << TUNE_W) || SWEEP_STEPS < 1 || UPD_LIMIT < 2)
      $error("tune_sweep_engine: bad parameters");
  end
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
  parameter int TUNE_W      = 6,
  parameter int SWEEP_STEPS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_req_o,
  input logic              xfer_req_o,
  input logic              upd_done_i,
  input logic              done_o,
  input logic              err_o,
  input logic              upd_timeout,
  input logic              sweep_phase,
  input logic [TUNE_W-1:0] tune_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_req_o && xfer_req_o)); // R3

  AST_XFER_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req_o) |-> $past(upd_done_i) && $past(upd_req_o)); // R3

  AST_TUNE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req_o && $past(upd_req_o) && !$past(upd_done_i) && !$past(upd_timeout))
      |-> $stable(tune_o)); // R3

  AST_SWEEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_phase |-> (32'(tune_o) < SWEEP_STEPS)); // R2

  AST_NO_XFER_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_timeout) |-> !xfer_req_o); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> $past(upd_done_i)); // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R8
endmodule

bind tune_sweep_engine tsw_checker #(
  .TUNE_W     (TUNE_W),
  .SWEEP_STEPS(SWEEP_STEPS)
) i_tsw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_req_o  (upd_req_o),
  .xfer_req_o (xfer_req_o),
  .upd_done_i (upd_done_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .upd_timeout(upd_timeout),
  .sweep_phase(sweep_phase),
  .tune_o     (tune_o)
);

// File: tb/test_tune_sweep_engine.sv
`timescale 1ns/1ps
module test_tune_sweep_engine;
  localparam int TW = 6;
  localparam int STEPS = 40;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic upd_done_i, res_valid_i, res_pass_i;
  logic [TW-1:0] tune_o;
  logic upd_req_o, xfer_req_o, done_o, err_o;

  int total = 0;
  int bad = 0;

  // Responder state
  logic [39:0] pass_mask = '0;
  logic [39:0] stall_mask = '0;
  logic fin_stall = 1'b0;
  int xfer_rises = 0;
  int stall_xfer = 0;
  int max_tune = 0;

  always #2 clk = ~clk;

  tune_sweep_engine #(
    .TUNE_W(TW), .SWEEP_STEPS(STEPS), .UPD_LIMIT(LIM)
  ) i_tune_sweep_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .upd_done_i(upd_done_i),
    .res_valid_i(res_valid_i), .res_pass_i(res_pass_i), .tune_o(tune_o),
    .upd_req_o(upd_req_o), .xfer_req_o(xfer_req_o), .done_o(done_o), .err_o(err_o)
  );

  // {pass mask, stall mask, expected tune, expected error}
  localparam logic [86:0] VECS [9] = '{
    {40'hFFFFFFFFFF, 40'h0000000000, 6'd19, 1'b0},
    {40'h0000000000, 40'h0000000000, 6'd39, 1'b1},
    {40'h00000FFC00, 40'h0000000000, 6'd14, 1'b0},
    {40'h0000F0003C, 40'h0000000000, 6'd3,  1'b0},
    {40'hFC00000007, 40'h0000000000, 6'd36, 1'b0},
    {40'h0000000001, 40'h0000000000, 6'd0,  1'b0},
    {40'hFFFFFFFFFF, 40'h0040000020, 6'd17, 1'b0},
    {40'h8000000000, 40'h0000000000, 6'd39, 1'b0},
    {40'h0000001F07, 40'h0000000000, 6'd10, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Card side and delay-line model
  initial begin
    int ucnt = 0;
    int xcnt = 0;
    logic xprev = 1'b0;
    logic hold;
    upd_done_i = 1'b0;
    res_valid_i = 1'b0;
    res_pass_i = 1'b0;
    forever begin
      @(negedge clk);
      upd_done_i = 1'b0;
      res_valid_i = 1'b0;
      res_pass_i = 1'b0;
      if (upd_req_o) begin
        if (int'(tune_o) > max_tune) max_tune = int'(tune_o);
        hold = ((tune_o < 6'd40) && stall_mask[tune_o]) || (fin_stall && xfer_rises == 40);
        if (!hold) begin
          ucnt++;
          if (ucnt >= 2) begin
            upd_done_i = 1'b1;
            ucnt = 0;
          end
        end
      end else begin
        ucnt = 0;
      end
      if (xfer_req_o) begin
        if (!xprev) begin
          xfer_rises++;
          if ((tune_o < 6'd40) && stall_mask[tune_o]) stall_xfer++;
        end
        xcnt++;
        if (xcnt >= 3) begin
          res_valid_i = 1'b1;
          res_pass_i = (tune_o < 6'd40) ? pass_mask[tune_o] : 1'b0;
          xcnt = 0;
        end
      end else begin
        xcnt = 0;
      end
      xprev = xfer_req_o;
    end
  end

  task automatic launch(input logic [39:0] pm, input logic [39:0] sm, input logic fs);
    pass_mask = pm;
    stall_mask = sm;
    fin_stall = fs;
    xfer_rises = 0;
    stall_xfer = 0;
    max_tune = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R1 sweep starts at code 0", int'(tune_o), 0);
    check("R1 update request after start", int'(upd_req_o), 1);
  endtask

  task automatic wait_done(output int t, output int e);
    int seen = 0;
    t = -1;
    e = -1;
    for (int c = 0; c < 5000; c++) begin
      if (done_o) begin
        seen = 1;
        t = int'(tune_o);
        e = int'(err_o);
        break;
      end
      @(negedge clk);
    end
    check("R7 done reached", seen, 1);
    @(negedge clk);
    check("R7 done lasts one cycle", int'(done_o), 0);
  endtask

  initial begin
    int t, e;
    repeat (3) @(negedge clk);
    check("R10 reset tune", int'(tune_o), 0);
    check("R10 reset requests", int'({upd_req_o, xfer_req_o}), 0);
    check("R10 reset done/err", int'({done_o, err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", int'({upd_req_o, xfer_req_o, done_o, err_o}), 0);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 9; v++) begin
      launch(VECS[v][86:47], VECS[v][46:7], 1'b0);
      wait_done(t, e);
      check($sformatf("R6 R5 vec%0d final code", v), t, int'(VECS[v][6:1]));
      check($sformatf("R8 vec%0d error flag", v), e, int'(VECS[v][0]));
      check($sformatf("R3 vec%0d transfers", v), xfer_rises, 40 - $countones(VECS[v][46:7]));
      check($sformatf("R4 vec%0d no transfer on stall", v), stall_xfer, 0);
      check($sformatf("R2 vec%0d top code applied", v), max_tune, 39);
    end

    // R8: after an empty sweep nothing is pending
    launch(40'h0, 40'h0, 1'b0);
    wait_done(t, e);
    check("R8 no final update request", int'(upd_req_o), 0);
    check("R8 tune keeps last swept code", int'(tune_o), 39);

    // R9: final update never completes
    launch(40'hFFFFFFFFFF, 40'h0, 1'b1);
    wait_done(t, e);
    check("R9 error on final timeout", e, 1);
    check("R9 final code still driven", t, 19);

    // R1: start during a sweep is ignored
    launch(40'hFFFFFFFFFF, 40'h0, 1'b0);
    for (int c = 0; c < 2000; c++) begin
      if (tune_o == 6'd10) break;
      @(negedge clk);
    end
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R1 busy start no restart", int'(tune_o >= 6'd10), 1);
    wait_done(t, e);
    check("R1 result unaffected", t, 19);
    check("R2 each code once despite start", xfer_rises, 40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule